// File: doc/BRIEF.md
# Windowed Service Watchdog

This block supervises software progress by counting instruction cycles between service writes. Software writes an 8-bit value on a simple write strobe. The first write after reset whose key field is correct fixes two choices until the next reset: the length of the upper service window and whether an external clock-frequency monitor is enabled. Every write after that is a service attempt. A service attempt is accepted only when it repeats the fixed key and the latched window choice.

A service must land inside a window. It may not come earlier than a fixed lower limit and must come before an upper limit that the latched selection picks. A late service, an early service or a malformed service raises an active-low fault output. The fault output stays low for a bounded hold time and is then released. Writes that arrive while the fault is active are ignored. When the fault is released, a fresh window starts from zero. A disable input forces the block idle: it holds the counters, clears any fault and ignores writes.

Top module: `svc_watchdog`

## Requirements
- R1: After reset `fault_n` is 1 and `mon_en` is 1. Before any configuration, the window selection is 2'b11, so the upper limit is `UP_BASE*8` cycles.
- R2: Before configuration, a write is acted on only if `wr_data[5:1]` equals 5'b01100. Such a write latches `wr_data[7:6]` as the window selection and `wr_data[0]` as `mon_en`. A write with a different key before configuration is ignored and does not raise a fault.
- R3: Once configured, the selection and `mon_en` cannot change until reset. A later write with the correct key but a different `wr_data[7:6]` is a violation and does not alter `mon_en`.
- R4: When no service arrives, `fault_n` falls after exactly `UP_BASE << sel` counted cycles since the window started, for each `sel` in 0..3.
- R5: A valid service is a write with `wr_data[7:1]` equal to {sel, 5'b01100}; bit 0 is ignored. When it arrives with a count of at least `LOW_LIM`, it restarts the count at zero and does not raise a fault. This includes a service in the last cycle of the window.
- R6: A valid service that arrives while the count is below `LOW_LIM` is a violation.
- R7: A service attempt whose key field differs from 5'b01100 is a violation.
- R8: After a violation, `fault_n` stays low for exactly `HOLD_CYC` cycles and then returns to 1. A new window starts at count zero when it is released.
- R9: Writes that arrive while `fault_n` is low are ignored. They change neither the hold time nor the configuration.
- R10: While `wd_off` is 1, the count is held at zero, `fault_n` is 1 by the next cycle, and writes (including configuration) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wd_off | input | 1 | 1 disables the block; 0 lets it run |
| wr_en | input | 1 | Write strobe for the service register |
| wr_data | input | 8 | Write data: [7:6] window selection, [5:1] key, [0] monitor enable |
| fault_n | output | 1 | Active-low fault output |
| mon_en | output | 1 | Latched clock-monitor enable |

## Verification
The embedded properties check on every cycle that:
- the latched configuration never moves once set;
- the cycle count stays within the selected window;
- an early service always raises the fault on the next cycle;
- the fault never releases before its hold ends;
- disabling the block clears the fault.

Only the bench scenarios can show the exact arithmetic of each upper limit, the precise hold length and the restart timing after release. They also show the boundary between an early service and an accepted one, and that writes during a fault or while disabled leave no trace.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [4:0] WD_KEY = 5'b01100;

    typedef struct packed {
        logic       done;
        logic [1:0] sel;
        logic       mon;
    } wd_cfg_t;

    typedef struct packed {
        logic        active;
        logic [7:0]  cnt;
    } wd_hold_t;

endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output wd_cfg_t    cfg,
    output logic       svc_ok,
    output logic       svc_bad
);

    wd_cfg_t cfg_d, cfg_q;
    logic    key_hit;

    always_comb begin
        cfg_d   = cfg_q;
        svc_ok  = 1'b0;
        svc_bad = 1'b0;
        key_hit = (wr_data[5:1] == WD_KEY);
        if (accept && wr_en) begin
            if (!cfg_q.done) begin
                if (key_hit) begin
                    cfg_d.done = 1'b1;
                    cfg_d.sel  = wr_data[7:6];
                    cfg_d.mon  = wr_data[0];
                end
            end else if (key_hit && (wr_data[7:6] == cfg_q.sel)) begin
                svc_ok = 1'b1;
            end else begin
                svc_bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{done: 1'b0, sel: 2'b11, mon: 1'b1};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R3: configuration is frozen once latched
    a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.done |=> (cfg_q.done && $stable(cfg_q.sel) && $stable(cfg_q.mon)));

endmodule

// File: rtl/wdog_span.sv
module wdog_span #(
    parameter int LOW_LIM = 2048,
    parameter int UP_BASE = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       svc_ok,
    input  logic [1:0] sel,
    output logic       early,
    output logic       late
);

    localparam int CNT_W = $clog2(UP_BASE * 8);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] top;

    always_comb begin
        top   = CNT_W'((32'(UP_BASE) << sel) - 32'd1);
        early = run && svc_ok && (cnt_q < CNT_W'(LOW_LIM));
        late  = run && !svc_ok && (cnt_q == top);
        if (!run || svc_ok || late) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R4: the count never passes the selected upper limit
    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= top);

endmodule

// File: rtl/wdog_hold.sv
module wdog_hold
    import wdog_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic off,
    input  logic trip,
    output logic fault
);

    localparam logic [7:0] LAST = 8'(HOLD_CYC - 1);

    wd_hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (off) begin
            st_d = '0;
        end else if (st_q.active) begin
            if (st_q.cnt == LAST) begin
                st_d = '0;
            end else begin
                st_d.cnt = st_q.cnt + 8'd1;
            end
        end else if (trip) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault = st_q.active;

    // R8: no release before the hold has run its full length
    a_r8_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && (st_q.cnt != LAST) && !off) |=> st_q.active);

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import wdog_pkg::*;
#(
    parameter int LOW_LIM  = 2048,
    parameter int UP_BASE  = 8192,
    parameter int HOLD_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd_off,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       fault_n,
    output logic       mon_en
);

    wd_cfg_t cfg;
    logic    svc_ok, svc_bad, early, late, fault, accept, trip;

    assign accept = !wd_off && !fault;
    assign trip   = svc_bad || early || late;

    wdog_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .svc_ok  (svc_ok),
        .svc_bad (svc_bad)
    );

    wdog_span #(.LOW_LIM(LOW_LIM), .UP_BASE(UP_BASE)) u_span (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (accept),
        .svc_ok (svc_ok),
        .sel    (cfg.sel),
        .early  (early),
        .late   (late)
    );

    wdog_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .off   (wd_off),
        .trip  (trip),
        .fault (fault)
    );

    assign fault_n = !fault;
    assign mon_en  = cfg.mon;

    // R10: disabling the block releases the fault output
    a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wd_off |=> fault_n);

    // R6: an early service always trips the fault
    a_r6_early_trips: assert property (@(posedge clk) disable iff (!rst_n)
        early |=> !fault_n);

    // R9: writes during a fault leave the configuration alone
    a_r9_fault_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && wr_en) |=> $stable(mon_en));

endmodule

// File: tb/svc_watchdog_test.sv
module svc_watchdog_test;

    localparam int LOW = 16;
    localparam int UPB = 64;
    localparam int HLD = 16;
    localparam logic [4:0] KEY = 5'b01100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_off = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fault_n, mon_en;

    int vectors = 0;
    int miscmp  = 0;

    always #4 clk = ~clk;

    svc_watchdog #(.LOW_LIM(LOW), .UP_BASE(UPB), .HOLD_CYC(HLD)) uut (
        .clk(clk), .rst_n(rst_n), .wd_off(wd_off), .wr_en(wr_en),
        .wr_data(wr_data), .fault_n(fault_n), .mon_en(mon_en)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscmp++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; wd_off = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] word(input logic [1:0] s, input logic m);
        return {s, KEY, m};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        miscmp++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 fault_n after reset", fault_n, 1);
        check("R1 mon_en after reset", mon_en, 1);

        // R4 and R8: every window selection, timeout, hold and restart
        for (int s = 0; s < 4; s++) begin
            int u;
            u = UPB << s;
            do_reset();
            wr(word(s[1:0], s[0]));
            check("R2 mon_en latched", mon_en, s & 1);
            step(u - 2);
            check("R4 no fault before limit", fault_n, 1);
            step(1);
            check("R4 fault at limit", fault_n, 0);
            step(HLD - 1);
            check("R8 still held", fault_n, 0);
            step(1);
            check("R8 released", fault_n, 1);
            step(u - 1);
            check("R8 restarted window, before limit", fault_n, 1);
            step(1);
            check("R8 restarted window, at limit", fault_n, 0);
        end

        // R5 and R6: sweep the service moment across the whole window (sel 0)
        for (int k = 1; k < UPB; k++) begin
            do_reset();
            wr(word(2'b00, 1'b1));
            step(k - 1);
            wr(word(2'b00, k[0]));
            if (k < LOW) begin
                check("R6 early service trips", fault_n, 0);
            end else begin
                check("R5 valid service accepted", fault_n, 1);
                step(UPB - 1);
                check("R5 window restarted", fault_n, 1);
                step(1);
                check("R5 timeout after restart", fault_n, 0);
            end
        end

        // R2, R3, R9
        do_reset();
        wr(8'h00);
        check("R2 bad key before config ignored", fault_n, 1);
        check("R2 bad key leaves mon_en", mon_en, 1);
        wr(word(2'b00, 1'b0));
        check("R2 config latches mon_en", mon_en, 0);
        step(LOW);
        wr(word(2'b00, 1'b1));
        check("R5 bit0 ignored in service", fault_n, 1);
        step(LOW + 4);
        wr(word(2'b01, 1'b1));
        check("R3 wrong window trips", fault_n, 0);
        check("R3 mon_en unchanged", mon_en, 0);
        wr(word(2'b10, 1'b1));
        wr(word(2'b00, 1'b0));
        check("R9 mon_en unchanged in fault", mon_en, 0);
        step(HLD - 3);
        check("R9 hold length unchanged", fault_n, 0);
        step(1);
        check("R9 released on time", fault_n, 1);
        step(UPB - 1);
        check("R3 selection frozen, before limit", fault_n, 1);
        step(1);
        check("R3 selection frozen, at limit", fault_n, 0);

        // R7 bad key after configuration
        do_reset();
        wr(word(2'b01, 1'b1));
        step(LOW + 4);
        wr(8'h5A);
        check("R7 bad key trips", fault_n, 0);

        // R10 disable
        do_reset();
        wd_off = 1'b1;
        wr(word(2'b00, 1'b0));
        check("R10 config ignored while off", mon_en, 1);
        wr(8'h00);
        step(200);
        check("R10 no fault while off", fault_n, 1);
        wd_off = 1'b0;
        step(UPB * 8 - 1);
        check("R1 default window, before limit", fault_n, 1);
        step(1);
        check("R1 default window, at limit", fault_n, 0);
        step(3);
        wd_off = 1'b1;
        step(1);
        check("R10 off clears fault", fault_n, 1);
        wd_off = 1'b0;
        step(UPB * 8 - 1);
        check("R10 count held at zero", fault_n, 1);
        step(1);
        check("R10 timeout after re-enable", fault_n, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule